// File: doc/BRIEF.md
# Dual-Output Programmable Reference Divider

This block divides one reference clock by a programmable ratio and turns the divided square wave into comparison strobes for two synthesizer loops, A and B. Loop A is strobed on the rising edge of the divided wave and loop B on the falling edge. The two loops therefore never receive an active event in the same input cycle. An optional select bit halves the comparison rate of loop B by passing only every second falling-edge strobe.

The ratio and the select bit are sampled only when the down-counter reloads, so reprogramming never cuts a period short. Ratios below the legal minimum are raised to it. A power-down input freezes the divider at zero. When it is released, counting starts with a fresh period.

Top module: `refdiv_dual`

## Requirements
- R1: While `rst_n` is low at a clock edge, `div_o`, `strobe_a_o` and `strobe_b_o` are 0 after that edge. After release, the first period begins as described in R8.
- R2: With ratio R (8..4095), `div_o` is periodic with period R input cycles. It is high for floor(R/2) cycles and then low for R - floor(R/2) cycles.
- R3: `strobe_a_o` is 1 for exactly one cycle, in the first high cycle of each period of `div_o`.
- R4: With select clear, `strobe_b_o` is 1 for exactly one cycle, in the first low cycle of every period, and never in the same cycle as `strobe_a_o`.
- R5: With select set (`half_b_i` = 1), `strobe_b_o` fires only on every second falling edge of `div_o`, beginning with the first fall after a reset or power-up.
- R6: A ratio value of 0 to 7 behaves exactly like ratio 8.
- R7: A change of `ratio_i` or `half_b_i` takes effect at the start of the next period. The period in progress keeps its length and mode.
- R8: While `pdn_i` is 1, all three outputs are 0 after each edge. The first edge with `pdn_i` = 0 starts a new period, and `div_o` and `strobe_a_o` rise one cycle later.
- R9: The maximum ratio 4095 yields a period of 4095 cycles, with 2047 of them high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference input clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ratio_i | input | 12 | Division ratio R |
| half_b_i | input | 1 | 1 = loop B compares at half rate |
| pdn_i | input | 1 | 1 = power-down, divider held at zero |
| strobe_a_o | output | 1 | Loop A comparison strobe (rising edge) |
| strobe_b_o | output | 1 | Loop B comparison strobe (falling edge) |
| div_o | output | 1 | Divided square wave |

## Verification
The assertions assume that `rst_n` starts low. They also assume that the ratio programmed at each reload gives a high phase of at least two cycles, which the clamp to 8 guarantees for every input value. The stimulus holds the inputs steady across each sampling edge by changing them only on falling clock edges. It sweeps every ratio from 0 to 40 in both modes and runs the maximum ratio. It also changes the ratio and the mode in the middle of a period and applies power-down and reset while the divider is running, so every input value stays inside what the checks assume.

// File: rtl/refdiv_pkg.sv
// Shared constants and types for the dual-output reference divider.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package refdiv_pkg;

    localparam int RATIO_W_DEF   = 12;
    localparam int RATIO_MIN_DEF = 8;

    // Transition seen on the divided wave in one cycle.
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_RISE = 2'd1,
        EV_FALL = 2'd2
    } edge_ev_t;

endpackage

// File: rtl/refdiv_count.sv
// Period down-counter. It reloads with the clamped ratio when idle or when the
// count reaches 1, and it latches the ratio-derived threshold and the half-rate
// select at that reload only.
// Assumes: RATIO_MIN >= 2, so the count never reaches 0 while running.
module refdiv_count #(
    parameter int RATIO_W   = refdiv_pkg::RATIO_W_DEF,
    parameter int RATIO_MIN = refdiv_pkg::RATIO_MIN_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pdn_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic               sel_i,
    output logic [RATIO_W-1:0] cnt_q,
    output logic [RATIO_W-1:0] thr_q,
    output logic               run_q,
    output logic               sel_q
);

    localparam logic [RATIO_W-1:0] MIN_V = RATIO_W'(RATIO_MIN);
    localparam logic [RATIO_W-1:0] ONE_V = RATIO_W'(1);

    logic [RATIO_W-1:0] ratio_eff;
    logic [RATIO_W-1:0] thr_eff;
    logic               reload;

    // Clamp the ratio and derive the high/low threshold, ceil(R/2).
    always_comb begin
        ratio_eff = (ratio_i < MIN_V) ? MIN_V : ratio_i;
        thr_eff   = ratio_eff - (ratio_eff >> 1);
        reload    = !run_q || (cnt_q == ONE_V);
    end

    // Count down, reload and latch the configuration at the period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || pdn_i) begin
            cnt_q <= '0;
            thr_q <= '0;
            run_q <= 1'b0;
            sel_q <= 1'b0;
        end else if (reload) begin
            cnt_q <= ratio_eff;
            thr_q <= thr_eff;
            run_q <= 1'b1;
            sel_q <= sel_i;
        end else begin
            cnt_q <= cnt_q - ONE_V;
        end
    end

endmodule

// File: rtl/refdiv_edge.sv
// Shapes the square wave from the counter state and reports the transition in
// each cycle. The wave is high while the count is above the threshold.
// Assumes: the counter holds its threshold constant for a whole period.
module refdiv_edge #(
    parameter int RATIO_W = refdiv_pkg::RATIO_W_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pdn_i,
    input  logic [RATIO_W-1:0]   cnt_q,
    input  logic [RATIO_W-1:0]   thr_q,
    input  logic                 run_q,
    output logic                 div_q,
    output refdiv_pkg::edge_ev_t ev
);

    import refdiv_pkg::*;

    logic div_raw;

    // Decode the wave level and classify it against the registered level.
    always_comb begin
        div_raw = run_q && (cnt_q > thr_q);
        if (div_raw && !div_q)
            ev = EV_RISE;
        else if (!div_raw && div_q)
            ev = EV_FALL;
        else
            ev = EV_NONE;
    end

    // Register the wave level.
    always_ff @(posedge clk) begin
        if (!rst_n || pdn_i) div_q <= 1'b0;
        else                 div_q <= div_raw;
    end

endmodule

// File: rtl/refdiv_strobe.sv
// Turns the transitions into one-cycle strobes: loop A on rises, loop B on
// falls. In half-rate mode a toggle passes every second fall, the first one first.
// Assumes: the select input is stable within a period (latched upstream).
module refdiv_strobe (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pdn_i,
    input  refdiv_pkg::edge_ev_t ev,
    input  logic                 sel_q,
    output logic                 str_a_q,
    output logic                 str_b_q
);

    import refdiv_pkg::*;

    logic cand_b;
    logic skip_q;

    // Flag a loop B candidate on each falling transition.
    always_comb cand_b = (ev == EV_FALL);

    // Register both strobes and advance the half-rate toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || pdn_i) begin
            str_a_q <= 1'b0;
            str_b_q <= 1'b0;
            skip_q  <= 1'b0;
        end else begin
            str_a_q <= (ev == EV_RISE);
            if (!sel_q) begin
                str_b_q <= cand_b;
                skip_q  <= 1'b0;
            end else begin
                str_b_q <= cand_b && !skip_q;
                if (cand_b) skip_q <= !skip_q;
            end
        end
    end

endmodule

// File: rtl/refdiv_dual.sv
// Top level of the dual-output reference divider: counter, wave shaper and
// strobe generator in a chain. All outputs are registered.
// Assumes: synchronous active-low reset; pdn_i is synchronous to clk.
module refdiv_dual #(
    parameter int RATIO_W   = refdiv_pkg::RATIO_W_DEF,
    parameter int RATIO_MIN = refdiv_pkg::RATIO_MIN_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic               half_b_i,
    input  logic               pdn_i,
    output logic               strobe_a_o,
    output logic               strobe_b_o,
    output logic               div_o
);

    logic [RATIO_W-1:0]   cnt_q;
    logic [RATIO_W-1:0]   thr_q;
    logic                 run_q;
    logic                 sel_q;
    refdiv_pkg::edge_ev_t ev;

    refdiv_count #(.RATIO_W(RATIO_W), .RATIO_MIN(RATIO_MIN)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .pdn_i   (pdn_i),
        .ratio_i (ratio_i),
        .sel_i   (half_b_i),
        .cnt_q   (cnt_q),
        .thr_q   (thr_q),
        .run_q   (run_q),
        .sel_q   (sel_q)
    );

    refdiv_edge #(.RATIO_W(RATIO_W)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pdn_i (pdn_i),
        .cnt_q (cnt_q),
        .thr_q (thr_q),
        .run_q (run_q),
        .div_q (div_o),
        .ev    (ev)
    );

    refdiv_strobe u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .pdn_i   (pdn_i),
        .ev      (ev),
        .sel_q   (sel_q),
        .str_a_q (strobe_a_o),
        .str_b_q (strobe_b_o)
    );

endmodule

// File: rtl/refdiv_dual_chk.sv
// Port-level properties of the dual-output reference divider, bound to the top.
// Assumes: rst_n is low at the first clock edge.
module refdiv_dual_chk (
    input logic clk,
    input logic rst_n,
    input logic pdn_i,
    input logic strobe_a_o,
    input logic strobe_b_o,
    input logic div_o
);

    // R1: reset forces every output low.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!div_o && !strobe_a_o && !strobe_b_o));

    // R3: the loop A strobe marks a rise of the wave.
    a_r3_a_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_a_o |-> (div_o && !$past(div_o)));

    // R2: the high phase lasts longer than one cycle.
    a_r2_high_min: assert property (@(posedge clk) disable iff (!rst_n || pdn_i)
        strobe_a_o |=> div_o);

    // R4: the loop B strobe marks a fall of the wave.
    a_r4_b_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_b_o |-> (!div_o && $past(div_o)));

    // R4: the two strobes never coincide.
    a_r4_never_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(strobe_a_o && strobe_b_o));

    // R8: power-down keeps the outputs at zero.
    a_r8_pdn_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        pdn_i |=> (!div_o && !strobe_a_o && !strobe_b_o));

endmodule

bind refdiv_dual refdiv_dual_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pdn_i      (pdn_i),
    .strobe_a_o (strobe_a_o),
    .strobe_b_o (strobe_b_o),
    .div_o      (div_o)
);

// File: tb/refdiv_dual_tb.sv
module refdiv_dual_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] ratio_i = 12'd8;
    logic        half_b_i = 1'b0;
    logic        pdn_i = 1'b0;
    logic        strobe_a_o;
    logic        strobe_b_o;
    logic        div_o;

    int    checks = 0;
    int    errors = 0;
    string tag = "R1";

    always #4 clk = ~clk;

    refdiv_dual u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ratio_i    (ratio_i),
        .half_b_i   (half_b_i),
        .pdn_i      (pdn_i),
        .strobe_a_o (strobe_a_o),
        .strobe_b_o (strobe_b_o),
        .div_o      (div_o)
    );

    // Arithmetic reference: the period position, latched at each period start.
    int m_run = 0, m_p = 0, m_r = 8, m_sr = 0, m_tog = 0;
    bit raw_div = 0, raw_sa = 0, raw_sb = 0;
    bit exp_div = 0, exp_sa = 0, exp_sb = 0;

    always @(posedge clk) begin
        if (!rst_n || pdn_i) begin
            exp_div = 0; exp_sa = 0; exp_sb = 0;
            m_run = 0; m_tog = 0;
            raw_div = 0; raw_sa = 0; raw_sb = 0;
        end else begin
            exp_div = raw_div; exp_sa = raw_sa; exp_sb = raw_sb;
            if (m_run == 0 || m_p == m_r - 1) begin
                m_r   = (int'(ratio_i) < 8) ? 8 : int'(ratio_i);
                m_sr  = int'(half_b_i);
                m_p   = 0;
                m_run = 1;
            end else begin
                m_p++;
            end
            raw_div = (m_p < m_r / 2);
            raw_sa  = (m_p == 0);
            raw_sb  = (m_p == m_r / 2) && (m_sr == 0 || m_tog == 0);
            if (m_sr == 0) m_tog = 0;
            else if (m_p == m_r / 2) m_tog = 1 - m_tog;
        end
    end

    task automatic check_now();
        checks += 3;
        if (div_o !== exp_div) begin
            errors++;
            $display("FAIL %s R2 div_o got %0b exp %0b at %0t", tag, div_o, exp_div, $time);
        end
        if (strobe_a_o !== exp_sa) begin
            errors++;
            $display("FAIL %s R3 strobe_a_o got %0b exp %0b at %0t", tag, strobe_a_o, exp_sa, $time);
        end
        if (strobe_b_o !== exp_sb) begin
            errors++;
            $display("FAIL %s R4/R5 strobe_b_o got %0b exp %0b at %0t", tag, strobe_b_o, exp_sb, $time);
        end
    endtask

    task automatic run(input int n);
        repeat (n) begin
            @(negedge clk);
            check_now();
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        // R1: outputs stay low during reset.
        tag = "R1";
        run(4);
        @(negedge clk);
        rst_n = 1'b1;
        run(30);

        // R2, R3, R4, R5, R6: sweep ratios 0..40 in both modes, fresh start each time.
        for (int sr = 0; sr < 2; sr++) begin
            for (int r = 0; r <= 40; r++) begin
                tag = (r < 8) ? "R6" : ((sr != 0) ? "R5" : "R2");
                pdn_i    = 1'b1;
                ratio_i  = 12'(r);
                half_b_i = sr[0];
                run(2);
                pdn_i = 1'b0;
                run(4 * ((r < 8) ? 8 : r) + 3);
            end
        end

        // R9: maximum ratio in half-rate mode.
        tag = "R9";
        ratio_i  = 12'd4095;
        half_b_i = 1'b1;
        pdn_i    = 1'b1;
        run(2);
        pdn_i = 1'b0;
        run(2 * 4095 + 20);
        half_b_i = 1'b0;
        run(4095 + 10);

        // R7: change ratio and mode in the middle of periods.
        tag = "R7";
        ratio_i = 12'd20;
        run(7);
        ratio_i  = 12'd13;
        half_b_i = 1'b1;
        run(11);
        ratio_i = 12'd9;
        run(5);
        ratio_i  = 12'd24;
        half_b_i = 1'b0;
        run(80);

        // R8: power-down in the middle of a period, then restart.
        tag = "R8";
        ratio_i  = 12'd11;
        half_b_i = 1'b1;
        run(17);
        pdn_i = 1'b1;
        run(10);
        pdn_i = 1'b0;
        run(60);

        // R1: reset in the middle of a period.
        tag = "R1";
        run(5);
        rst_n = 1'b0;
        run(3);
        rst_n = 1'b1;
        run(50);

        summary();
        $finish;
    end

endmodule